// File: doc/BRIEF.md
# Mask-Selected GPIO Line Configuration Bank

This block is one bank of 32 general-purpose I/O lines, configured through a small synchronous register bus. Software first writes a line-select mask. It then reaches the settings of every selected line through a single shared configuration word. A configuration write goes to all selected lines at once. A configuration read shows the settings of one selected line. Each line's settings are its function code, direction, pull-up and pull-down, glitch filter and filter clock choice, open-drain drive, Schmitt input disable and an event code.

Output levels are changed through a set word and a clear word. In both, only the 1 bits act. A read-only word returns the output latches. Another read-only word returns the pin levels after a two-flop synchronizer. The pad side gives per-line output level and output enable, and takes the raw pin inputs.

The bus uses word addressing. Word index n corresponds to byte offset 4·n, and the bank spans 0x40 bytes. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, the mask, every line's configuration and every output latch are 0, so `pad_oe` and `pad_out` are all 0.
- R2: Word index 0 (byte 0x00) is the 32-bit line-select mask. It can be written and read back.
- R3: A write to word index 1 (byte 0x04) loads the configuration of every line whose mask bit is 1. Lines whose mask bit is 0 keep their settings.
- R4: A read of word index 1 returns the configuration of the lowest-numbered selected line. It returns 0 when the mask is 0.
- R5: The configuration word has these fields: bits [2:0] function (0 = plain GPIO), bit 8 direction (1 = output), bit 9 pull-up, bit 10 pull-down, bit 12 filter enable, bit 13 filter on slow clock, bit 14 open-drain, bit 15 Schmitt input disabled, and bits [26:24] event code. All other bits read as 0.
- R6: Writing word index 4 (byte 0x10) sets the output latch of every line that has a 1 bit. Writing word index 5 (byte 0x14) clears the latch of every line that has a 1 bit. Lines with 0 bits are unchanged. Word index 6 (byte 0x18) reads the latches, and `pad_out` equals the latches.
- R7: `pad_oe` of a line is 1 only when its direction bit is 1 and it is not the case that both open-drain and the latch are 1.
- R8: Word index 2 (byte 0x08) returns `pad_in` through two flops. A level applied before clock edge k is readable after edge k+1 and not after edge k.
- R9: Writes to word indices 2 and 6 have no effect. Writes to all other unused indices have no effect. Unused indices read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word index within the bank |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Raw pin levels |
| pad_out | output | 32 | Output level per line |
| pad_oe | output | 32 | Output enable per line |

## Verification
The assertions assume that `bus_we` is a plain strobe held for a single cycle per access. They also assume that `pad_in` may change on any cycle; nothing assumes it is stable, because the synchronizer check compares against the input two cycles earlier. The stimulus drives the address, data and strobe only at falling edges. It keeps each write to one cycle. It changes `pad_in` at falling edges only, so each rising edge sees one settled value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Word indices within a bank
  localparam logic [3:0] IDX_MASK  = 4'd0;
  localparam logic [3:0] IDX_CFG   = 4'd1;
  localparam logic [3:0] IDX_LEVEL = 4'd2;
  localparam logic [3:0] IDX_SET   = 4'd4;
  localparam logic [3:0] IDX_CLR   = 4'd5;
  localparam logic [3:0] IDX_LATCH = 4'd6;

  typedef struct packed {
    logic [2:0] evt;
    logic       schm_off;
    logic       od;
    logic       filt_slow;
    logic       filt_en;
    logic       pd;
    logic       pu;
    logic       dir;
    logic [2:0] func;
  } line_cfg_t;

  function automatic line_cfg_t cfg_from_word(input logic [31:0] w);
    line_cfg_t c;
    c.func      = w[2:0];
    c.dir       = w[8];
    c.pu        = w[9];
    c.pd        = w[10];
    c.filt_en   = w[12];
    c.filt_slow = w[13];
    c.od        = w[14];
    c.schm_off  = w[15];
    c.evt       = w[26:24];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input line_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[2:0]   = c.func;
    w[8]     = c.dir;
    w[9]     = c.pu;
    w[10]    = c.pd;
    w[12]    = c.filt_en;
    w[13]    = c.filt_slow;
    w[14]    = c.od;
    w[15]    = c.schm_off;
    w[26:24] = c.evt;
    return w;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

  // checker warm-up: cycles since reset, saturating at 2
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R8
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_line.sv
module gpio_line
  import gpio_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  line_cfg_t cfg_wd,
  input  logic      set_stb,
  input  logic      clr_stb,
  output line_cfg_t cfg_q,
  output logic      latch_q,
  output logic      oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wd;
      if (set_stb)      latch_q <= 1'b1;
      else if (clr_stb) latch_q <= 1'b0;
    end
  end

  // open-drain: a 1 on the latch releases the pad
  logic od_release;
  assign od_release = cfg_q.od & latch_q;
  assign oe         = cfg_q.dir & ~od_release;

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wd)));
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
  // R6
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> latch_q);
  // R6
  latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> !latch_q);
  // R7
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.dir |-> !oe);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NLINES  = 32,
  parameter int WORD_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] bus_addr,
  input  logic               bus_we,
  input  logic [NLINES-1:0]  bus_wdata,
  output logic [NLINES-1:0]  bus_rdata,
  input  logic [NLINES-1:0]  pad_in,
  output logic [NLINES-1:0]  pad_out,
  output logic [NLINES-1:0]  pad_oe
);
  localparam int SELW = (NLINES > 1) ? $clog2(NLINES) : 1;

  // decoded write strobes
  logic mask_we, cfg_we, set_we, clr_we;
  assign mask_we = bus_we && (bus_addr == WORD_AW'(IDX_MASK));
  assign cfg_we  = bus_we && (bus_addr == WORD_AW'(IDX_CFG));
  assign set_we  = bus_we && (bus_addr == WORD_AW'(IDX_SET));
  assign clr_we  = bus_we && (bus_addr == WORD_AW'(IDX_CLR));

  logic [NLINES-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= bus_wdata;
  end

  line_cfg_t cfg_wd;
  assign cfg_wd = cfg_from_word(32'(bus_wdata));

  line_cfg_t         cfg_all [NLINES];
  logic [NLINES-1:0] latch_all;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    gpio_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we && mask_q[i]),
      .cfg_wd  (cfg_wd),
      .set_stb (set_we && bus_wdata[i]),
      .clr_stb (clr_we && bus_wdata[i]),
      .cfg_q   (cfg_all[i]),
      .latch_q (latch_all[i]),
      .oe      (pad_oe[i])
    );
  end

  assign pad_out = latch_all;

  logic [NLINES-1:0] level_sync;
  gpio_in_sync #(.WIDTH(NLINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (level_sync)
  );

  // lowest selected line
  logic [SELW-1:0] first_sel;
  logic            any_sel;
  always_comb begin
    first_sel = '0;
    any_sel   = 1'b0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (mask_q[i]) begin
        first_sel = SELW'(i);
        any_sel   = 1'b1;
      end
    end
  end

  logic [NLINES-1:0] cfg_rd;
  assign cfg_rd = any_sel ? NLINES'(cfg_to_word(cfg_all[first_sel])) : '0;

  always_comb begin
    case (bus_addr)
      WORD_AW'(IDX_MASK):  bus_rdata = mask_q;
      WORD_AW'(IDX_CFG):   bus_rdata = cfg_rd;
      WORD_AW'(IDX_LEVEL): bus_rdata = level_sync;
      WORD_AW'(IDX_LATCH): bus_rdata = latch_all;
      default:             bus_rdata = '0;
    endcase
  end

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
  // R4
  cfg_empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == WORD_AW'(IDX_CFG)) && (mask_q == '0)) |-> (bus_rdata == '0));
  // R6
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(pad_out));
endmodule

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_bank_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // vector: {req[3:0], op[1:0], addr[3:0], data[31:0]}
  // op 0 = write, 1 = read and compare, 2 = compare pad_oe, 3 = compare pad_out
  localparam int NV = 26;
  localparam logic [41:0] VEC [NV] = '{
    {4'd2, 2'd0, 4'd0, 32'h0000_0030},   // R2 mask lines 4,5
    {4'd2, 2'd1, 4'd0, 32'h0000_0030},   // R2 readback
    {4'd3, 2'd0, 4'd1, 32'h0200_0303},   // R3 func3 out pull-up evt2
    {4'd3, 2'd0, 4'd0, 32'h0000_0020},   // R3 select line 5 only
    {4'd5, 2'd0, 4'd1, 32'hFFFF_FFFF},   // R5 all ones into line 5
    {4'd3, 2'd0, 4'd0, 32'h0000_0031},   // R3 lines 0,4,5
    {4'd4, 2'd1, 4'd1, 32'h0000_0000},   // R4 lowest is line 0, untouched
    {4'd3, 2'd0, 4'd0, 32'h0000_0030},
    {4'd3, 2'd1, 4'd1, 32'h0200_0303},   // R3 line 4 kept its value
    {4'd4, 2'd0, 4'd0, 32'h0000_0020},
    {4'd5, 2'd1, 4'd1, 32'h0700_F707},   // R5 only defined bits kept
    {4'd7, 2'd2, 4'd0, 32'h0000_0030},   // R7 both outputs driving
    {4'd6, 2'd0, 4'd4, 32'h0000_00F0},   // R6 set 4..7
    {4'd6, 2'd1, 4'd6, 32'h0000_00F0},
    {4'd6, 2'd3, 4'd0, 32'h0000_00F0},
    {4'd7, 2'd2, 4'd0, 32'h0000_0010},   // R7 line 5 open-drain high released
    {4'd6, 2'd0, 4'd5, 32'h0000_0030},   // R6 clear 4,5
    {4'd6, 2'd1, 4'd6, 32'h0000_00C0},
    {4'd7, 2'd2, 4'd0, 32'h0000_0030},
    {4'd4, 2'd0, 4'd0, 32'h0000_0000},
    {4'd4, 2'd1, 4'd1, 32'h0000_0000},   // R4 empty mask reads 0
    {4'd9, 2'd0, 4'd6, 32'h0000_FFFF},   // R9 latch word is read-only
    {4'd9, 2'd1, 4'd6, 32'h0000_00C0},
    {4'd9, 2'd0, 4'd15, 32'h0000_1234},
    {4'd9, 2'd1, 4'd15, 32'h0000_0000},  // R9 unused index reads 0
    {4'd9, 2'd0, 4'd2, 32'hFFFF_FFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v); check("R1 mask", v, 32'h0);
    rd(4'd1, v); check("R1 cfg", v, 32'h0);
    rd(4'd6, v); check("R1 latch", v, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  req;
      logic [1:0]  op;
      logic [3:0]  a;
      logic [31:0] d;
      {req, op, a, d} = VEC[i];
      case (op)
        2'd0: wr(a, d);
        2'd1: begin rd(a, v); check($sformatf("R%0d vec%0d read", req, i), v, d); end
        2'd2: check($sformatf("R%0d vec%0d oe", req, i), pad_oe, d);
        default: check($sformatf("R%0d vec%0d out", req, i), pad_out, d);
      endcase
    end

    // R8 synchronizer latency; the earlier write to index 2 changed nothing
    @(negedge clk);
    rd(4'd2, v); check("R8 level before", v, 32'h0);
    pad_in = 32'hA5A5_5A5A;
    @(negedge clk);
    rd(4'd2, v); check("R8 level after one edge", v, 32'h0);
    @(negedge clk);
    rd(4'd2, v); check("R8 level after two edges", v, 32'hA5A5_5A5A);
    pad_in = 32'h0000_0001;
    @(negedge clk); @(negedge clk);
    rd(4'd2, v); check("R8 level second value", v, 32'h0000_0001);

    // R1 reset again clears mask, config and latches
    wr(4'd0, 32'h0000_0010);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'd0, v); check("R1 mask after reset", v, 32'h0);
    wr(4'd0, 32'h0000_0010);
    rd(4'd1, v); check("R1 line 4 cfg after reset", v, 32'h0);
    check("R1 pad_out after reset", pad_out, 32'h0);
    check("R1 pad_oe after reset", pad_oe, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule